// File: doc/BRIEF.md
# Configurable Logic Macrocell

The block is one cell of programmable logic. It takes a sum-of-products result, a dedicated set term and a dedicated reset term, a product-term clock, a set of global clocks and the pin input of the adjacent cell. A static configuration word sets the following:

- the storage mode: pass-through, edge flip-flop, toggle flip-flop or level latch;
- which clock drives the cell, and whether that clock is inverted;
- the polarity of the set term and of the reset term;
- whether the data comes from the logic sum or from the adjacent pin;
- the polarity of the pad output.

The cell drives two outputs. The feedback output always carries the cell result. The pad output carries the same result after a polarity stage.

Every clock source is treated as an ordinary signal. The cell runs on one system clock `clk`. On each `clk` edge it compares the selected source with its value at the previous `clk` edge to find the active transition. A transition counts as an edge when the source, after the polarity choice, goes from 0 to 1 between two samples. The storage element then updates on that `clk` edge. The set and reset terms force the result at once, without waiting for any edge. They also force the stored value at the next `clk` edge. The configuration word is expected to stay still while the cell is running.

Top module: `mc_macrocell`

## Requirements
- R1: A synchronous active-high `rst` clears the stored value to 0. After reset, in flip-flop mode with no set or reset term active, `fb_o` is 0.
- R2: With `cfg_i[1:0]`=0 (pass-through), `fb_o` equals the selected data input in the same cycle.
- R3: With `cfg_i[1:0]`=1 (edge flip-flop), the stored value takes the data input on a `clk` edge where the selected clock level has gone from 0 to 1 since the previous `clk` edge. At every other `clk` edge the stored value holds.
- R4: With `cfg_i[1:0]`=2 (toggle flip-flop), the stored value inverts on an active edge when the data input is 1. It holds when the data input is 0, and it holds when there is no active edge.
- R5: With `cfg_i[1:0]`=3 (latch), `fb_o` follows the data input while the selected clock level is 1. While that level is 0, `fb_o` holds the last value the latch took.
- R6: `cfg_i[4:2]` values 0 to 3 select `gclk_i` bit 0 to bit 3. Values 4 to 7 select `pt_clk_i`. Clock inputs that are not selected have no effect on the outputs.
- R7: `cfg_i[5]`=1 inverts the selected clock. The flip-flops then capture on its falling transition, and the latch is transparent while the clock is low.
- R8: The set term is active when `set_pt_i` XOR `cfg_i[6]` is 1. The reset term is active when `rst_pt_i` XOR `cfg_i[7]` is 1. An active set forces `fb_o` to 1 in the same cycle, and an active reset forces it to 0 in the same cycle. Either one also forces the stored value at the next `clk` edge.
- R9: When the set term and the reset term are both active, the reset wins and the result is 0.
- R10: `cfg_i[8]`=1 takes the data input from `nbr_pin_i`. `cfg_i[8]`=0 takes it from `sum_pt_i`. This applies in every storage mode.
- R11: `fb_o` always carries the cell result. `pad_o` equals `fb_o` XOR `cfg_i[9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 10 | Static configuration word (fields as in R2 to R11) |
| sum_pt_i | input | 1 | Sum-of-products data term |
| set_pt_i | input | 1 | Asynchronous set product term |
| rst_pt_i | input | 1 | Asynchronous reset product term |
| pt_clk_i | input | 1 | Product-term clock source |
| gclk_i | input | 4 | Global clock sources |
| nbr_pin_i | input | 1 | Pin input of the adjacent cell |
| fb_o | output | 1 | Feedback result |
| pad_o | output | 1 | Pad output after polarity control |

## Verification
The bench sweeps every one of the 1024 configuration words. Under each word it drives pseudo-random clock, data and force terms, and compares both outputs with a step-per-clock model.

- A clock selector that decodes the wrong index, or that ignores the product-term range, lets unselected clocks update the cell.
- An edge detector that does not respect the inversion bit captures on the wrong transition.
- A latch that is transparent on the wrong level follows the data when it should hold.
- Set and reset polarity is checked with the term both at 0 and at 1. An inverted polarity shows up as a constant forced output.
- A design that gives set priority over reset shows 1 where the model expects 0.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int unsigned MC_NUM_GCLK = 4;
    localparam int unsigned MC_SEL_W    = $clog2(MC_NUM_GCLK + 1);

    typedef enum logic [1:0] {
        MODE_COMB  = 2'd0,
        MODE_DFF   = 2'd1,
        MODE_TFF   = 2'd2,
        MODE_LATCH = 2'd3
    } store_mode_e;

    typedef struct packed {
        logic                out_inv;
        logic                din_pin;
        logic                rst_inv;
        logic                set_inv;
        logic                clk_inv;
        logic [MC_SEL_W-1:0] clk_sel;
        store_mode_e         mode;
    } mc_cfg_t;

    localparam int unsigned MC_CFG_W = $bits(mc_cfg_t);

    function automatic logic term_active(input logic term, input logic inv);
        return term ^ inv;
    endfunction

endpackage

// File: rtl/mc_clk_select.sv
module mc_clk_select
    import mc_pkg::*;
#(
    parameter int unsigned NUM_GCLK = MC_NUM_GCLK,
    parameter int unsigned SEL_W    = MC_SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                inv_i,
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic                pt_clk_i,
    output logic                lvl_o,
    output logic                edge_o
);

    logic [NUM_GCLK-1:0] hit;
    logic                use_pt;
    logic                raw;
    logic                prev_q;

    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_src
        assign hit[g] = (sel_i == SEL_W'(g)) & gclk_i[g];
    end

    assign use_pt = (sel_i >= SEL_W'(NUM_GCLK));
    assign raw    = (|hit) | (use_pt & pt_clk_i);
    assign lvl_o  = raw ^ inv_i;
    assign edge_o = lvl_o & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= lvl_o;
        else     prev_q <= lvl_o;
    end

    // R7: an edge needs a low sample first, so two in a row cannot occur
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o); // R7

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  store_mode_e mode_i,
    input  logic        d_i,
    input  logic        lvl_i,
    input  logic        edge_i,
    input  logic        set_act_i,
    input  logic        rst_act_i,
    output logic        res_o
);

    logic q_r;
    logic nxt;

    always_comb begin
        nxt = q_r;
        unique case (mode_i)
            MODE_COMB:  nxt = d_i;
            MODE_DFF:   if (edge_i) nxt = d_i;
            MODE_TFF:   if (edge_i && d_i) nxt = ~q_r;
            MODE_LATCH: if (lvl_i) nxt = d_i;
            default:    nxt = q_r;
        endcase
        if (set_act_i) nxt = 1'b1;
        if (rst_act_i) nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= nxt;
    end

    always_comb begin
        if (rst_act_i)                              res_o = 1'b0;
        else if (set_act_i)                         res_o = 1'b1;
        else if (mode_i == MODE_COMB)               res_o = d_i;
        else if (mode_i == MODE_LATCH && lvl_i)     res_o = d_i;
        else                                        res_o = q_r;
    end

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        rst_act_i |=> !q_r); // R9

    AST_SET_FORCE: assert property (@(posedge clk) disable iff (rst)
        (set_act_i && !rst_act_i) |=> q_r); // R8

    AST_DFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_DFF && !edge_i && !set_act_i && !rst_act_i) |=> $stable(q_r)); // R3

    AST_TFF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_TFF && edge_i && d_i && !set_act_i && !rst_act_i)
            |=> (q_r != $past(q_r))); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_LATCH && !lvl_i && !set_act_i && !rst_act_i) |=> $stable(q_r)); // R5

endmodule

// File: rtl/mc_pad_out.sv
module mc_pad_out (
    input  logic res_i,
    input  logic inv_i,
    output logic fb_o,
    output logic pad_o
);

    assign fb_o  = res_i;
    assign pad_o = inv_i ? ~res_i : res_i;

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int unsigned NUM_GCLK = MC_NUM_GCLK,
    parameter int unsigned CFG_W    = MC_CFG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_i,
    input  logic                sum_pt_i,
    input  logic                set_pt_i,
    input  logic                rst_pt_i,
    input  logic                pt_clk_i,
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic                nbr_pin_i,
    output logic                fb_o,
    output logic                pad_o
);

    mc_cfg_t cfg;
    logic    d_sel;
    logic    set_act;
    logic    rst_act;
    logic    lvl;
    logic    edge_p;
    logic    res;

    assign cfg     = mc_cfg_t'(cfg_i);
    assign d_sel   = cfg.din_pin ? nbr_pin_i : sum_pt_i;
    assign set_act = term_active(set_pt_i, cfg.set_inv);
    assign rst_act = term_active(rst_pt_i, cfg.rst_inv);

    mc_clk_select #(
        .NUM_GCLK (NUM_GCLK),
        .SEL_W    (MC_SEL_W)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (cfg.clk_sel),
        .inv_i    (cfg.clk_inv),
        .gclk_i   (gclk_i),
        .pt_clk_i (pt_clk_i),
        .lvl_o    (lvl),
        .edge_o   (edge_p)
    );

    mc_store u_store (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (cfg.mode),
        .d_i       (d_sel),
        .lvl_i     (lvl),
        .edge_i    (edge_p),
        .set_act_i (set_act),
        .rst_act_i (rst_act),
        .res_o     (res)
    );

    mc_pad_out u_pad (
        .res_i (res),
        .inv_i (cfg.out_inv),
        .fb_o  (fb_o),
        .pad_o (pad_o)
    );

endmodule

// File: tb/tb_mc_macrocell.sv
`timescale 1ns/1ps
module tb_mc_macrocell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] cfg_i = 10'd1;
    logic       sum_pt_i = 1'b0;
    logic       set_pt_i = 1'b0;
    logic       rst_pt_i = 1'b0;
    logic       pt_clk_i = 1'b0;
    logic [3:0] gclk_i = 4'd0;
    logic       nbr_pin_i = 1'b0;
    logic       fb_o;
    logic       pad_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic       mq;
    logic       mprev;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    mc_macrocell dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg_i),
        .sum_pt_i  (sum_pt_i),
        .set_pt_i  (set_pt_i),
        .rst_pt_i  (rst_pt_i),
        .pt_clk_i  (pt_clk_i),
        .gclk_i    (gclk_i),
        .nbr_pin_i (nbr_pin_i),
        .fb_o      (fb_o),
        .pad_o     (pad_o)
    );

    function automatic logic m_lvl();
        logic s;
        s = (cfg_i[4:2] < 3'd4) ? gclk_i[cfg_i[3:2]] : pt_clk_i;
        return s ^ cfg_i[5];
    endfunction

    function automatic logic m_d();
        return cfg_i[8] ? nbr_pin_i : sum_pt_i;
    endfunction

    function automatic logic m_fb();
        logic sa, ra;
        sa = set_pt_i ^ cfg_i[6];
        ra = rst_pt_i ^ cfg_i[7];
        if (ra) return 1'b0;
        if (sa) return 1'b1;
        if (cfg_i[1:0] == 2'd0) return m_d();
        if (cfg_i[1:0] == 2'd3 && m_lvl()) return m_d();
        return mq;
    endfunction

    function automatic string tag_of();
        logic sa, ra;
        sa = set_pt_i ^ cfg_i[6];
        ra = rst_pt_i ^ cfg_i[7];
        if (sa && ra) return "R9";
        if (sa || ra) return "R8";
        if (cfg_i[8] && cfg_i[1:0] == 2'd1) return "R10";
        if (cfg_i[5] && cfg_i[1:0] != 2'd0) return "R7";
        if (cfg_i[4] && cfg_i[1:0] == 2'd1) return "R6";
        case (cfg_i[1:0])
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b cfg=%h", req, act, exp, cfg_i);
        end
    endtask

    task automatic m_update();
        logic sa, ra, lv, ed;
        sa = set_pt_i ^ cfg_i[6];
        ra = rst_pt_i ^ cfg_i[7];
        lv = m_lvl();
        ed = lv & ~mprev;
        if (ra)      mq = 1'b0;
        else if (sa) mq = 1'b1;
        else case (cfg_i[1:0])
            2'd0: mq = m_d();
            2'd1: if (ed) mq = m_d();
            2'd2: if (ed && m_d()) mq = ~mq;
            default: if (lv) mq = m_d();
        endcase
        mprev = lv;
    endtask

    task automatic do_reset();
        set_pt_i = cfg_i[6];
        rst_pt_i = cfg_i[7];
        rst = 1'b1;
        @(posedge clk);
        mq = 1'b0;
        mprev = m_lvl();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gclk_i    = lfsr[3:0];
        pt_clk_i  = lfsr[4];
        sum_pt_i  = lfsr[5];
        nbr_pin_i = lfsr[6];
        set_pt_i  = cfg_i[6] ^ (lfsr[9:7] == 3'd0);
        rst_pt_i  = cfg_i[7] ^ (lfsr[12:10] == 3'd0);
        #1;
        check(tag_of(), fb_o, m_fb());
        check("R11", pad_o, m_fb() ^ cfg_i[9]);
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state in flip-flop mode with no force terms
        cfg_i = 10'd1;
        do_reset();
        #1;
        check("R1", fb_o, 1'b0);
        check("R1", pad_o, 1'b0);
        @(negedge clk);

        // R6: toggling unselected clocks leaves a D cell unchanged
        cfg_i = 10'b00_0000_0001; // D mode, gclk 0, no inversions
        do_reset();
        sum_pt_i = 1'b1;
        gclk_i = 4'b1110;
        pt_clk_i = 1'b1;
        @(posedge clk); @(negedge clk);
        #1;
        check("R6", fb_o, 1'b0);
        @(negedge clk);

        for (int c = 0; c < 1024; c++) begin
            cfg_i = c[9:0];
            do_reset();
            for (int k = 0; k < 12; k++) step();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule